// File: doc/BRIEF.md
# Demodulating Capture Timer

This block is a down-counting timer with a 16-bit count. In its plain timer use, a write to the control register loads the count from a two-byte reload register. The count then falls by one on every prescaled tick. The tick after the count reaches zero is the terminal tick. That tick sets a sticky time-out flag, toggles a timer output line and loads the count again.

In demodulation use, edges on a synchronized input line (rising and falling alike) measure the time between events. Each accepted edge latches the elapsed count since the last reload into two capture bytes in a single cycle, sets a capture flag and reloads the counter. A single-edge option accepts only the first edge after arming. Arming happens on a control write or on a time-out.

Two level interrupt outputs follow the flags through their mask bits. A shared pin carries either the ordinary port data or the timer output.

Top module: `dcap_timer`

## Requirements
- R1: After reset, every register reads 0, both interrupt outputs are low and `pin_out` follows `port_dout`. Registers: address 0 control, 1 status, 2 and 3 reload low and high, 4 and 5 capture low and high. Unused addresses read 0.
- R2: Control bit 0 enables counting. Any control write reloads the count. With a divide of 1 and reload N, the time-out flag (status bit 0) is first readable as 1 right after the (N+1)th rising clock edge following the control write's edge, and not one edge before.
- R3: The time-out flag stays set until a status write with bit 0 at 1. A status write of 0 leaves it unchanged.
- R4: `irq_timeout` is high exactly while the time-out flag and control bit 6 are both 1.
- R5: Control bits 4:3 (value k) divide the tick rate by 2^k. With reload N, the first time-out lands (N+1)*2^k clock edges after the control write.
- R6: With control bit 1 set and bit 2 clear, every edge of `demod_in` captures (reload minus current count) into the capture bytes, with both bytes written in the same cycle, and reloads the counter. At a divide of 1, two edges D cycles apart capture D-1. The capture flag is status bit 1; writing 1 to that bit clears it.
- R7: With control bit 2 set, only the first edge after arming captures. Later edges leave the capture bytes unchanged.
- R8: Single-edge mode is rearmed by any control write and by a time-out. An edge driven N cycles after a control write at a divide of 1 captures N+2, because input synchronization adds latency.
- R9: `irq_capture` is high exactly while the capture flag and control bit 5 are both 1.
- R10: With control bit 7 at 0, `pin_out` equals `port_dout`. With bit 7 at 1, `pin_out` carries the timer output, which is 0 after reset and toggles on every terminal tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| demod_in | input | 1 | Asynchronous input whose edges are measured |
| port_dout | input | 1 | Ordinary port data for the shared pin |
| pin_out | output | 1 | Shared pin: port data or timer output |
| irq_capture | output | 1 | Masked capture interrupt |
| irq_timeout | output | 1 | Masked time-out interrupt |

## Verification
The count register cannot be read, so a corrupted count first shows at the ports as a time-out landing on the wrong clock edge, or as a wrong captured value at the next edge. Both appear within one reload period. A stuck arming state shows when the capture bytes fail to change after a rearm, or change on an edge that should be ignored. The bench places each edge at a known cycle offset so that an off-by-one in latency or arithmetic changes the captured byte.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // control register field positions
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_DEMOD  = 1;
  localparam int unsigned CB_ONCE   = 2;
  localparam int unsigned CB_CAPM   = 5;
  localparam int unsigned CB_TMOM   = 6;
  localparam int unsigned CB_PINSEL = 7;

  // register addresses
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_RLD  = 2;
  localparam int unsigned A_CAP  = 4;

  typedef struct packed {
    logic       pin_sel;
    logic       tmo_mask;
    logic       cap_mask;
    logic [1:0] cks;
    logic       once;
    logic       demod;
    logic       en;
  } ctrl_t;

  // low bits of the prescaler that must all be 1 for a tick
  function automatic logic [7:0] div_mask(input logic [1:0] cks);
    return 8'((1 << cks) - 1);
  endfunction

endpackage

// File: rtl/dct_prescale.sv
module dct_prescale #(
  parameter int unsigned PSW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] cks,
  output logic       tick
);
  import dct_pkg::*;

  logic [PSW-1:0] pre;
  logic [PSW-1:0] mask;

  always_comb mask = PSW'(div_mask(cks));

  assign tick = run && !restart && ((pre & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre <= '0;
    else if (restart) pre <= '0;
    else if (run)     pre <= pre + 1'b1;
  end
endmodule

// File: rtl/dct_edge.sv
module dct_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_ev
);
  // sh[STAGES-1] is the last synchronizer stage, sh[STAGES] its delayed copy
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign edge_ev = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/dct_core.sv
module dct_core #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          edge_ev,
  input  logic          run,
  input  logic          demod,
  input  logic          once,
  input  logic [CW-1:0] reload,
  input  logic          tmo_clr,
  input  logic          cap_clr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] cap_val,
  output logic          tmo_flag,
  output logic          cap_flag,
  output logic          tout,
  output logic          armed,
  output logic          term_ev,
  output logic          cap_ev
);

  function automatic logic [CW-1:0] elapsed(input logic [CW-1:0] rl,
                                            input logic [CW-1:0] cur);
    return rl - cur;
  endfunction

  assign cap_ev  = run && demod && edge_ev && (!once || armed) && !restart;
  assign term_ev = tick && (count == '0) && !cap_ev && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (restart)          count <= reload;
    else if (cap_ev || term_ev) count <= reload;
    else if (tick)             count <= count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_val <= '0;
    else if (cap_ev) cap_val <= elapsed(reload, count);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   armed <= 1'b1;
    else if (restart || term_ev)  armed <= 1'b1;
    else if (cap_ev && once)      armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmo_flag <= 1'b0;
    else if (term_ev) tmo_flag <= 1'b1;
    else if (tmo_clr) tmo_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_flag <= 1'b0;
    else if (cap_ev)  cap_flag <= 1'b1;
    else if (cap_clr) cap_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tout <= 1'b0;
    else if (term_ev) tout <= ~tout;
  end
endmodule

// File: rtl/dcap_timer.sv
module dcap_timer #(
  parameter int unsigned CW          = 16,
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 3,
  parameter int unsigned PSW         = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          demod_in,
  input  logic          port_dout,
  output logic          pin_out,
  output logic          irq_capture,
  output logic          irq_timeout
);
  import dct_pkg::*;

  localparam int unsigned NB = CW / DW;

  ctrl_t          ctrl;
  logic [CW-1:0]  reload_q;
  logic           ctrl_wr, stat_wr;
  logic           tmo_clr, cap_clr;
  logic           tick, edge_ev;
  logic [CW-1:0]  count, cap_val;
  logic           tmo_flag, cap_flag, tout, armed;
  logic           term_ev, cap_ev;
  logic           once_q;

  assign ctrl_wr = bus_wr && (bus_addr == AW'(A_CTRL));
  assign stat_wr = bus_wr && (bus_addr == AW'(A_STAT));
  assign tmo_clr = stat_wr && bus_wdata[0];
  assign cap_clr = stat_wr && bus_wdata[1];
  assign once_q  = ctrl.once;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata[7:0]);
  end

  for (genvar i = 0; i < NB; i++) begin : g_rld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reload_q[i*DW +: DW] <= '0;
      else if (bus_wr && (bus_addr == AW'(A_RLD + i)))
        reload_q[i*DW +: DW] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_CTRL)) bus_rdata = DW'(ctrl);
    if (bus_addr == AW'(A_STAT)) bus_rdata = DW'({cap_flag, tmo_flag});
    for (int i = 0; i < NB; i++) begin
      if (bus_addr == AW'(A_RLD + i)) bus_rdata = reload_q[i*DW +: DW];
      if (bus_addr == AW'(A_CAP + i)) bus_rdata = cap_val[i*DW +: DW];
    end
  end

  dct_prescale #(.PSW(PSW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl.en), .restart(ctrl_wr),
    .cks(ctrl.cks), .tick(tick)
  );

  dct_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(demod_in), .edge_ev(edge_ev)
  );

  dct_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(ctrl_wr),
    .edge_ev(edge_ev), .run(ctrl.en), .demod(ctrl.demod), .once(ctrl.once),
    .reload(reload_q), .tmo_clr(tmo_clr), .cap_clr(cap_clr),
    .count(count), .cap_val(cap_val), .tmo_flag(tmo_flag),
    .cap_flag(cap_flag), .tout(tout), .armed(armed),
    .term_ev(term_ev), .cap_ev(cap_ev)
  );

  assign irq_capture = cap_flag && ctrl.cap_mask;
  assign irq_timeout = tmo_flag && ctrl.tmo_mask;
  assign pin_out     = ctrl.pin_sel ? tout : port_dout;
endmodule

// File: rtl/dct_chk.sv
module dct_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          term_ev,
  input logic          cap_ev,
  input logic          tmo_flag,
  input logic          cap_flag,
  input logic          tout,
  input logic          armed,
  input logic          once_q,
  input logic          ctrl_wr,
  input logic [CW-1:0] count,
  input logic [CW-1:0] reload_q
);
  // R2
  tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_ev |=> tmo_flag);

  // R2
  tmo_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_ev |=> (count == $past(reload_q)));

  // R6
  cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> cap_flag);

  // R7
  once_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev && once_q && !ctrl_wr) |=> !armed);

  // R10
  tout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !term_ev |=> $stable(tout));

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_ev || ctrl_wr) |=> armed);
endmodule

bind dcap_timer dct_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .term_ev(term_ev), .cap_ev(cap_ev),
  .tmo_flag(tmo_flag), .cap_flag(cap_flag), .tout(tout), .armed(armed),
  .once_q(once_q), .ctrl_wr(ctrl_wr), .count(count), .reload_q(reload_q)
);

// File: tb/sim_dcap_timer.sv
module sim_dcap_timer;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       demod_in = 1'b0;
  logic       port_dout = 1'b0;
  logic       pin_out, irq_capture, irq_timeout;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  dcap_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .demod_in(demod_in),
    .port_dout(port_dout), .pin_out(pin_out),
    .irq_capture(irq_capture), .irq_timeout(irq_timeout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; demod_in = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    do_reset;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reg read", d, 0);
    end
    chk("R1 irq_capture", irq_capture, 0);
    chk("R1 irq_timeout", irq_timeout, 0);
    port_dout = 1'b1; #0.1;
    chk("R1 pin follows port", pin_out, 1);
    port_dout = 1'b0;
  endtask

  task automatic t_timer;
    logic [7:0] d;
    do_reset;
    wr(2, 8'd5); wr(3, 8'd0);
    wr(0, 8'h41);
    repeat (5) @(negedge clk);
    rd(1, d);
    chk("R2 no timeout before N+1", d, 0);
    chk("R4 irq low before timeout", irq_timeout, 0);
    @(negedge clk);
    rd(1, d);
    chk("R2 timeout at N+1", d, 8'h01);
    chk("R4 irq_timeout", irq_timeout, 1);
    wr(0, 8'h00);
    rd(1, d);
    chk("R3 flag survives ctrl write", d[0], 1);
    chk("R4 masked irq", irq_timeout, 0);
    wr(1, 8'h00);
    rd(1, d);
    chk("R3 write 0 no effect", d[0], 1);
    wr(1, 8'h01);
    rd(1, d);
    chk("R3 write 1 clears", d[0], 0);
  endtask

  task automatic t_prescale;
    logic [7:0] d;
    do_reset;
    wr(2, 8'd3); wr(3, 8'd0);
    wr(0, 8'h11);
    repeat (15) @(negedge clk);
    rd(1, d);
    chk("R5 div4 not yet", d, 0);
    @(negedge clk);
    rd(1, d);
    chk("R5 div4 timeout", d, 8'h01);
  endtask

  task automatic t_demod_all;
    logic [7:0] lo, hi, st;
    do_reset;
    wr(2, 8'h00); wr(3, 8'h10);
    wr(0, 8'h23);
    @(negedge clk); demod_in = ~demod_in;
    repeat (20) @(negedge clk); demod_in = ~demod_in;
    repeat (4) @(negedge clk);
    rd(4, lo); rd(5, hi); rd(1, st);
    chk("R6 cap lo D=20", lo, 8'd19);
    chk("R6 cap hi D=20", hi, 8'd0);
    chk("R6 cap flag", st, 8'h02);
    chk("R9 irq_capture", irq_capture, 1);
    wr(1, 8'h02);
    rd(1, st);
    chk("R6 cap flag clear", st, 0);
    chk("R9 irq_capture clear", irq_capture, 0);
    @(negedge clk); demod_in = ~demod_in;
    repeat (300) @(negedge clk); demod_in = ~demod_in;
    repeat (4) @(negedge clk);
    rd(4, lo); rd(5, hi);
    chk("R6 cap lo D=300", lo, 8'h2B);
    chk("R6 cap hi D=300", hi, 8'h01);
  endtask

  task automatic t_single;
    logic [7:0] lo;
    do_reset;
    wr(2, 8'h00); wr(3, 8'h10);
    wr(0, 8'h27);
    repeat (6) @(negedge clk); demod_in = ~demod_in;
    repeat (10) @(negedge clk);
    rd(4, lo);
    chk("R8 first edge latency", lo, 8'd8);
    demod_in = ~demod_in;
    repeat (4) @(negedge clk);
    rd(4, lo);
    chk("R7 later edge ignored", lo, 8'd8);
    wr(0, 8'h27);
    repeat (3) @(negedge clk); demod_in = ~demod_in;
    repeat (4) @(negedge clk);
    rd(4, lo);
    chk("R8 rearm by ctrl write", lo, 8'd5);
  endtask

  task automatic t_rearm_tmo;
    logic [7:0] lo, st;
    do_reset;
    wr(2, 8'd30); wr(3, 8'd0);
    wr(0, 8'h07);
    repeat (4) @(negedge clk); demod_in = ~demod_in;
    repeat (10) @(negedge clk);
    rd(4, lo);
    chk("R7 single first capture", lo, 8'd6);
    repeat (36) @(negedge clk); demod_in = ~demod_in;
    repeat (4) @(negedge clk);
    rd(4, lo); rd(1, st);
    chk("R8 rearm by timeout", lo, 8'd14);
    chk("R8 both flags", st, 8'h03);
    chk("R9 capture irq masked", irq_capture, 0);
  endtask

  task automatic t_pin;
    do_reset;
    port_dout = 1'b1; #0.1;
    chk("R10 port path high", pin_out, 1);
    port_dout = 1'b0; #0.1;
    chk("R10 port path low", pin_out, 0);
    wr(2, 8'd5); wr(3, 8'd0);
    port_dout = 1'b1;
    wr(0, 8'h81);
    chk("R10 timer path initial", pin_out, 0);
    repeat (6) @(negedge clk);
    chk("R10 toggle 1", pin_out, 1);
    repeat (6) @(negedge clk);
    chk("R10 toggle 2", pin_out, 0);
    port_dout = 1'b0;
  endtask

  initial begin
    t_reset;
    t_timer;
    t_prescale;
    t_demod_all;
    t_single;
    t_rearm_tmo;
    t_pin;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule